// File: doc/BRIEF.md
# Mode-Dependent Data Clock Divider

This block derives the data-rate clock from a reference clock. The division ratio is not set by a single register: it comes from the interpolation factor, whether zero stuffing is on, and whether the input samples arrive on two parallel ports or interleaved on one. A two-bit post-divide field then scales that base ratio. One mode combination has no legal ratio and is flagged instead of clocked.

Every divisor is a power of two. Ratios above one give a square wave with 50% duty cycle. A ratio of one passes the reference clock straight through. The block registers the mode inputs. Any change to them restarts the divide counter from zero, so the new ratio starts from a clean low phase. The total divisor and an invalid flag are reported alongside the clock.

Top module: `dclk_divider`

## Requirements
- R1: `interp_sel` codes 00, 01, 10, 11 select interpolation 1, 2, 4, 8. With `interleaved`=0 and `zero_stuff`=0, the base divisor equals the interpolation factor.
- R2: With `interleaved`=1 and `zero_stuff`=0, interpolation 1 is invalid. Interpolation 2, 4, 8 give base divisors 1, 2, 4.
- R3: With `interleaved`=0 and `zero_stuff`=1, the base divisor is twice the interpolation factor (2, 4, 8, 16).
- R4: With `interleaved`=1 and `zero_stuff`=1, the base divisor equals the interpolation factor.
- R5: `extra_div` multiplies the base divisor: 00 by 1, 01 by 2, 10 by 4, 11 by 1.
- R6: A combined divisor above 32 is treated as an invalid configuration. The reported divisor is therefore never above 32.
- R7: `divisor` reports the combined ratio as a power of two, or 0 when the configuration is invalid. It updates on the first reference rising edge after an input change.
- R8: For a divisor N above 1, the output is low for the first N/2 reference cycles after a restart, then high for N/2 cycles, and repeats with period N.
- R9: When the divisor is 1, `data_clk` follows `clk_ref`.
- R10: When the configuration is invalid, `cfg_invalid` is 1 and `data_clk` stays low.
- R11: Any change of `interp_sel`, `zero_stuff`, `interleaved` or `extra_div` restarts the divide counter at zero on the next reference rising edge.
- R12: While `rst_n` is low, `data_clk` is low, `cfg_invalid` is 0 and `divisor` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interp_sel | input | 2 | Interpolation code (1, 2, 4, 8) |
| zero_stuff | input | 1 | Zero stuffing enabled |
| interleaved | input | 1 | 1 = interleaved input, 0 = dual-port input |
| extra_div | input | 2 | Post-divide code |
| data_clk | output | 1 | Divided data clock |
| divisor | output | 6 | Combined divisor, 0 when invalid |
| cfg_invalid | output | 1 | Configuration has no legal ratio |

## Verification
The assertions assume the mode inputs change only between reference edges and stay stable around each rising edge. Under that assumption, a difference between the live inputs and the registered copy means a true change. The bench changes inputs only on falling edges and holds them for whole cycles. Before each waveform check, it forces a distinct invalid setting, so the target setting always counts as a change and causes a restart.

// File: rtl/dclk_divider.sv
module dclk_divider #(
  parameter int MAX_DIV = 32
) (
  input  logic                           clk_ref,
  input  logic                           rst_n,
  input  logic [1:0]                     interp_sel,
  input  logic                           zero_stuff,
  input  logic                           interleaved,
  input  logic [1:0]                     extra_div,
  output logic                           data_clk,
  output logic [$clog2(MAX_DIV):0]       divisor,
  output logic                           cfg_invalid
);
  localparam int CW = $clog2(MAX_DIV);
  localparam int DW = CW + 1;

  logic [5:0]    cfg, cfg_q;
  logic [CW-1:0] cnt, mask;
  logic [3:0]    base_lg, lg;
  logic          bad_mode, div_hi;

  assign cfg = {interp_sel, zero_stuff, interleaved, extra_div};

  always_comb begin
    bad_mode = 1'b0;
    case (cfg_q[3:2])
      2'b00: base_lg = {2'b00, cfg_q[5:4]};
      2'b01: begin
        bad_mode = (cfg_q[5:4] == 2'b00);
        base_lg  = bad_mode ? 4'd0 : {2'b00, cfg_q[5:4]} - 4'd1;
      end
      2'b10:   base_lg = {2'b00, cfg_q[5:4]} + 4'd1;
      default: base_lg = {2'b00, cfg_q[5:4]};
    endcase
    case (cfg_q[1:0])
      2'b01:   lg = base_lg + 4'd1;
      2'b10:   lg = base_lg + 4'd2;
      default: lg = base_lg;
    endcase
  end

  assign cfg_invalid = bad_mode || (lg > 4'(CW));
  assign divisor     = cfg_invalid ? '0 : DW'(1) << lg;
  assign mask        = cfg_invalid ? '0 : CW'(divisor - DW'(1));
  assign div_hi      = cnt > (mask >> 1);
  assign data_clk    = rst_n && !cfg_invalid && ((lg == 4'd0) ? clk_ref : div_hi);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt   <= '0;
    end else if (cfg != cfg_q) begin
      cfg_q <= cfg;
      cnt   <= '0;
    end else begin
      cnt <= CW'(cnt + 1'b1) & mask;
    end
  end

  a_r11_restart: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cfg != cfg_q) |=> (cnt == '0));
  a_r8_count_step: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cfg == cfg_q) |=> (cnt == (CW'($past(cnt) + 1'b1) & $past(mask))));
  a_r6_bounded: assert property (@(posedge clk_ref) disable iff (!rst_n)
    divisor <= DW'(MAX_DIV));
  a_r7_power_of_two: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $onehot0(divisor));
  a_r10_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cfg_invalid |-> !data_clk);
endmodule

// File: tb/test_dclk_divider.sv
`timescale 1ns/1ps
module test_dclk_divider;
  logic clk_ref = 1'b0, rst_n = 1'b0;
  logic [1:0] interp_sel = 2'b00, extra_div = 2'b00;
  logic zero_stuff = 1'b0, interleaved = 1'b0;
  logic data_clk, cfg_invalid;
  logic [5:0] divisor;
  int checks = 0, errors = 0;
  bit done = 0;

  dclk_divider i_dclk_divider (.clk_ref(clk_ref), .rst_n(rst_n), .interp_sel(interp_sel),
    .zero_stuff(zero_stuff), .interleaved(interleaved), .extra_div(extra_div),
    .data_clk(data_clk), .divisor(divisor), .cfg_invalid(cfg_invalid));

  always #2.5 clk_ref = ~clk_ref;

  function automatic int model(int ip, int zs, int il, int ex);
    int f, b, m;
    f = 1 << ip;
    if (zs == 0) b = (il != 0) ? ((ip == 0) ? 0 : f / 2) : f;
    else         b = (il != 0) ? f : 2 * f;
    m = (ex == 1) ? 2 : (ex == 2) ? 4 : 1;
    if (b == 0 || b * m > 32) return 0;
    return b * m;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(int ip, int zs, int il, int ex);
    @(negedge clk_ref);
    interp_sel = 2'(ip); zero_stuff = 1'(zs); interleaved = 1'(il); extra_div = 2'(ex);
  endtask

  task automatic t_reset;
    #1;
    chk("R12 clk", int'(data_clk), 0);
    chk("R12 flag", int'(cfg_invalid), 0);
    chk("R12 div", int'(divisor), 1);
    @(negedge clk_ref); rst_n = 1'b1;
  endtask

  task automatic t_table;
    for (int c = 0; c < 64; c++) begin
      int ip, zs, il, ex, e;
      ip = c >> 4; zs = (c >> 3) & 1; il = (c >> 2) & 1; ex = c & 3;
      e = model(ip, zs, il, ex);
      apply(ip, zs, il, ex);
      @(posedge clk_ref); #1;
      if (zs == 0 && il == 0) chk("R1", int'(divisor), e);
      else if (zs == 0)       chk("R2", int'(divisor), e);
      else if (il == 0)       chk("R3", int'(divisor), e);
      else                    chk("R4", int'(divisor), e);
      if (ex != 0) chk("R5", int'(divisor), e);
      chk("R6 R7 flag", int'(cfg_invalid), (e == 0) ? 1 : 0);
    end
  endtask

  task automatic wave(int ip, int zs, int il, int ex, string req);
    int n;
    n = model(ip, zs, il, ex);
    apply(0, 0, 1, 0);
    apply(ip, zs, il, ex);
    for (int k = 0; k < 2 * n; k++) begin
      @(posedge clk_ref); #1;
      chk(req, int'(data_clk), ((k % n) >= n / 2) ? 1 : 0);
    end
  endtask

  task automatic t_waves;
    wave(0, 1, 0, 0, "R8 div2");
    wave(1, 0, 0, 2, "R8 div8");
    wave(3, 0, 1, 1, "R8 div8 il");
    wave(2, 1, 0, 2, "R8 div32");
    wave(3, 1, 1, 0, "R8 div8 zs");
  endtask

  task automatic t_pass;
    apply(1, 0, 1, 3);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_ref); #1;
      chk("R9 high", int'(data_clk), 1);
      @(negedge clk_ref); #1;
      chk("R9 low", int'(data_clk), 0);
    end
  endtask

  task automatic t_invalid;
    apply(3, 1, 0, 2);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_ref); #1;
      chk("R10 clk", int'(data_clk), 0);
      chk("R10 flag", int'(cfg_invalid), 1);
      @(negedge clk_ref); #1;
      chk("R10 clk neg", int'(data_clk), 0);
    end
  endtask

  task automatic t_restart;
    apply(3, 1, 1, 0);
    repeat (6) @(posedge clk_ref);
    apply(3, 1, 1, 1);
    for (int k = 0; k < 32; k++) begin
      @(posedge clk_ref); #1;
      chk("R11", int'(data_clk), ((k % 16) >= 8) ? 1 : 0);
    end
  endtask

  initial begin
    t_reset;
    t_table;
    t_waves;
    t_pass;
    t_invalid;
    t_restart;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_ref);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule